// File: doc/BRIEF.md
# Reverse-subtract-and-skip accumulator core

This is a processor with a single instruction. Each instruction word holds only an operand address x. When the core runs it, it computes mem[x] minus the accumulator. It writes that difference back to mem[x] and also loads it into the accumulator. If the subtraction needed a borrow, the core skips the next instruction.

There is no program counter register. The program counter is memory word 0, and the core reads and rewrites it like any other data word. Because of this, a program can jump by naming word 0 as its operand.

The core drives a single-port synchronous memory. A read returns its data one cycle after the address is presented. The memory image is loaded from outside the core before reset is released, and word 0 of that image is the starting program counter. When the core writes to the highest address, it stops and raises `halted`.

Top module: `rssb_core`

## Requirements
- R1: While reset is held, and right after it, the accumulator is 0, `halted` is low and no write is issued. Every instruction begins with a read of address 0.
- R2: The operand address x is the low ADDR_W bits of the instruction word. The result mem[x] - acc, taken modulo 2^DATA_W, is written to mem[x] and becomes the new accumulator value.
- R3: A borrow occurs when mem[x] is less than acc as an unsigned number. A borrow skips the next instruction, so word 0 advances by 2. Equal values give no borrow.
- R4: Without a borrow, word 0 advances by 1 once the result has been written.
- R5: When x is 0, the result becomes the new program counter, and no increment is applied to it afterwards.
- R6: When x is the highest address, the result is still written. After that, `halted` goes high and stays high, no further write is issued, and the accumulator holds its value.
- R7: An ordinary instruction takes 5 cycles. An instruction whose operand is address 0 or the highest address takes 4 cycles.
- R8: The instruction sequence that uses a scratch word to compute x = y - z leaves y - z in x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Write enable for the current cycle |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after its address |
| halted | output | 1 | High once the halt address has been written |
| acc_out | output | DATA_W | Current accumulator value |

## Verification
An instruction moves through five phases: read word 0, read the instruction, read the operand, execute, and write back the program counter. Because of this, `halted` rises a fixed number of edges after reset is released: 9 edges for one ordinary instruction followed by a halt, and 13 edges for an ordinary instruction, then a jump, then a halt. The bench counts rising edges from the release of reset and samples on the falling edge, so each count is exact. It compares the final accumulator and memory words with hand-computed values and with an instruction-level model in the bench. After a halt, it watches for several further cycles that no write is issued.

// File: rtl/rssb_core.sv
module rssb_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [DATA_W-1:0] acc_out
);
  localparam logic [ADDR_W-1:0] HALT_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] PC_ADDR   = '0;
  localparam logic [DATA_W-1:0] STEP1     = DATA_W'(1);
  localparam logic [DATA_W-1:0] STEP2     = DATA_W'(2);

  typedef enum logic [2:0] {S_PC, S_INS, S_OPR, S_EXE, S_PCW, S_HALT} state_t;

  state_t            state;
  logic [DATA_W-1:0] acc, pc_q;
  logic [ADDR_W-1:0] opnd;
  logic              brw_q;

  logic [DATA_W:0]   sub_full;
  assign sub_full = {1'b0, mem_rdata} - {1'b0, acc};

  wire [DATA_W-1:0] diff   = sub_full[DATA_W-1:0];
  wire              borrow = sub_full[DATA_W];

  assign halted  = (state == S_HALT);
  assign acc_out = acc;

  always_comb begin
    mem_addr  = PC_ADDR;
    mem_we    = 1'b0;
    mem_wdata = '0;
    case (state)
      S_INS, S_OPR: mem_addr = mem_rdata[ADDR_W-1:0];
      S_EXE: begin
        mem_addr  = opnd;
        mem_we    = 1'b1;
        mem_wdata = diff;
      end
      S_PCW: begin
        mem_we    = 1'b1;
        mem_wdata = pc_q + (brw_q ? STEP2 : STEP1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_PC;
      acc   <= '0;
      pc_q  <= '0;
      opnd  <= '0;
      brw_q <= 1'b0;
    end else begin
      case (state)
        S_PC:  state <= S_INS;
        S_INS: begin
          pc_q  <= mem_rdata;
          state <= S_OPR;
        end
        S_OPR: begin
          opnd  <= mem_rdata[ADDR_W-1:0];
          state <= S_EXE;
        end
        S_EXE: begin
          acc   <= diff;
          brw_q <= borrow;
          if (opnd == HALT_ADDR)    state <= S_HALT;
          else if (opnd == PC_ADDR) state <= S_PC;
          else                      state <= S_PCW;
        end
        S_PCW:   state <= S_PC;
        default: state <= S_HALT;
      endcase
    end
  end

  p_fetch_pc_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PC) |-> (!mem_we && mem_addr == PC_ADDR));

  p_acc_mirrors_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && state == S_EXE) |=> (acc_out == $past(mem_wdata)));

  p_pc_written_after_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXE && opnd != PC_ADDR && opnd != HALT_ADDR) |=> (mem_we && mem_addr == PC_ADDR));

  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_no_write_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  p_acc_frozen_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> $stable(acc_out));
endmodule

// File: tb/rssb_core_tb.sv
module rssb_core_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        halted;
  logic [15:0] acc_out;

  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] mem   [256];
  logic [15:0] ref_m [256];
  logic [15:0] model_acc;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rssb_core #(.DATA_W(16), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted), .acc_out(acc_out)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(int a, logic [15:0] d);
    ld_addr = 8'(a);
    ld_data = d;
    ld_en   = 1'b1;
    ref_m[a] = d;
    @(negedge clk);
    ld_en   = 1'b0;
  endtask

  task automatic clear_image();
    rst_n = 1'b0;
    @(negedge clk);
    for (int a = 0; a < 256; a++) put(a, 16'h0000);
  endtask

  task automatic model_run();
    logic [15:0] a = '0;
    for (int n = 0; n < 1000; n++) begin
      logic [15:0] pc = ref_m[0];
      logic [7:0]  x  = ref_m[pc[7:0]][7:0];
      logic [15:0] d  = ref_m[x] - a;
      logic        b  = ref_m[x] < a;
      ref_m[x] = d;
      a = d;
      if (x == 8'hFF) break;
      if (x != 8'h00) ref_m[0] = pc + (b ? 16'd2 : 16'd1);
    end
    model_acc = a;
  endtask

  task automatic run_to_halt(output int edges);
    edges = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (halted) break;
    end
  endtask

  task automatic compare_model(string req);
    int bad = 0;
    model_run();
    chk(req, acc_out, model_acc);
    for (int a = 0; a < 256; a++) if (mem[a] !== ref_m[a]) bad++;
    chk({req, " image"}, 16'(bad), 16'd0);
  endtask

  task automatic t_reset();
    clear_image();
    chk("R1 acc", acc_out, 16'h0000);
    chk("R1 halted", {15'd0, halted}, 16'd0);
    chk("R1 we", {15'd0, mem_we}, 16'd0);
    chk("R1 addr", {8'd0, mem_addr}, 16'd0);
  endtask

  task automatic t_plain();
    int e;
    clear_image();
    put(0, 16'd8); put(8, 16'h1214); put(9, 16'h00FF); put(20, 16'd5);
    run_to_halt(e);
    chk("R7 cycles plain", 16'(e), 16'd9);
    chk("R2 acc", acc_out, 16'hFFFB);
    chk("R2 mem", mem[20], 16'd5);
    chk("R4 pc", mem[0], 16'd9);
    chk("R6 halt word", mem[255], 16'hFFFB);
    compare_model("R2 model");
  endtask

  task automatic t_borrow();
    int e;
    clear_image();
    put(0, 16'd8); put(8, 16'd20); put(9, 16'd21); put(10, 16'd22); put(11, 16'd255);
    put(20, 16'd3); put(21, 16'd1); put(22, 16'd7);
    run_to_halt(e);
    chk("R3 skipped word", mem[22], 16'd7);
    chk("R3 borrow result", mem[21], 16'hFFFE);
    chk("R3 pc", mem[0], 16'd11);
    chk("R3 acc", acc_out, 16'd2);
    compare_model("R3 model");
  endtask

  task automatic t_equal();
    int e;
    clear_image();
    put(0, 16'd8); put(8, 16'd20); put(9, 16'd21); put(10, 16'd22); put(11, 16'd255);
    put(20, 16'd4); put(21, 16'd4); put(22, 16'd7);
    run_to_halt(e);
    chk("R3 equal zero", mem[21], 16'd0);
    chk("R4 not skipped", mem[22], 16'd7);
    chk("R4 acc", acc_out, 16'hFFF9);
    chk("R4 pc", mem[0], 16'd11);
  endtask

  task automatic t_jump();
    int e;
    clear_image();
    put(0, 16'd8); put(8, 16'd20); put(9, 16'd0); put(10, 16'd21); put(17, 16'd255);
    put(20, 16'hFFF8); put(21, 16'd5);
    run_to_halt(e);
    chk("R7 cycles jump", 16'(e), 16'd13);
    chk("R5 pc", mem[0], 16'd17);
    chk("R5 untouched", mem[21], 16'd5);
    chk("R5 acc", acc_out, 16'hFFEF);
    compare_model("R5 model");
  endtask

  task automatic t_halt_hold();
    int writes = 0;
    logic [15:0] a0 = acc_out;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (mem_we) writes++;
    end
    chk("R6 no writes", 16'(writes), 16'd0);
    chk("R6 halted", {15'd0, halted}, 16'd1);
    chk("R6 acc held", acc_out, a0);
  endtask

  task automatic t_sub_prog();
    int e;
    int seq [17] = '{100,100,100,102,100,103,103,103,103,101,103,103,100,103,103,103,103};
    clear_image();
    put(0, 16'd8);
    for (int i = 0; i < 17; i++) put(8 + i, 16'(seq[i]));
    put(25, 16'd255); put(26, 16'd255);
    put(100, 16'd9); put(101, 16'd50); put(102, 16'd20); put(103, 16'd4);
    run_to_halt(e);
    chk("R8 difference", mem[100], 16'd30);
    chk("R8 y kept", mem[101], 16'd50);
    compare_model("R8 model");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_plain();
    t_halt_hold();
    t_borrow();
    t_equal();
    t_jump();
    t_halt_hold();
    t_sub_prog();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule